// File: doc/BRIEF.md
# Backlight Pulse-Width Modulator with Atomic Duty Update

This block drives a panel backlight with a pulse train whose period and high time are set by configuration inputs. A bit-count field picks how many bits of the period value are used. The high time comes from the top bits of a 16-bit duty word. In fractional mode, the remaining low bits of the duty word are spread over successive periods by an error accumulator, so the average brightness gets finer steps than one counter tick.

Duty values never reach the output directly. Each write lands in a staging register. The staged word moves into the active duty register only at the start of a period, and only while no lock applies, so a period is never built from a half-changed value. Software can hold a group lock while it stages a value. After the lock is released, an update-pending flag stays high until the transfer has happened. A master lock also exists, and a per-group override bit can make the group ignore it. The counter advances only on cycles where the clock-enable input is high; this input stands in for the reference divider.

Top module: `backlight_pwm`

## Requirements
- R1: A bit-count of 0 means 16 bits. The period input is masked to its low bit-count bits. A masked period of 0 gives a period of 65535 counts.
- R2: With fractional mode off, the high time in counts is the duty word shifted right by (16 minus bit-count). Duty bits below that part have no effect.
- R3: With fractional mode on, the duty bits below the integer part are left-aligned into a 16-bit fraction. At each period start this fraction is added to a 16-bit accumulator. A carry out lengthens that period's high time by one count. The accumulator starts at zero when output is enabled.
- R4: A high time equal to or longer than the period keeps the output high for the whole period. A high time of 0 keeps it low.
- R5: While the enable input is 0, the output is 0, the counter rests at its start, and the accumulator is cleared. After reset the output, the active duty and the pending flag are all 0.
- R6: A duty write always goes to the staging register. The staged value becomes the active duty, visible on the readback port, only in a clock-enabled cycle where the counter is at its start. While the output is disabled, every clock-enabled cycle is such a start. The period that begins with a transfer already uses the new value.
- R7: The effective lock is the group lock OR (the master lock AND NOT the ignore-master bit). While the effective lock is set, no transfer takes place.
- R8: The update-pending output is 1 while a staged value waits and the effective lock is clear. It returns to 0 after the transfer edge.
- R9: A duty write in the same cycle as a transfer has this result: the older staged value becomes active, and the new value stays staged, with pending set, until the next start.
- R10: In a cycle with clock-enable low, the counter, the output level, the accumulator and the active duty all hold their values.
- R11: The output is registered. The first clock-enabled edge after enable rises handles count 0, and each later enabled edge handles the next count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Count enable (divided reference tick) |
| pwmEn | input | 1 | Output enable |
| bitCnt | input | 4 | Period width select (0 means 16) |
| periodIn | input | 16 | Period value before masking |
| fracEn | input | 1 | Fractional duty mode |
| dutyIn | input | 16 | Duty word to stage |
| dutyWr | input | 1 | Write strobe for dutyIn |
| grpLock | input | 1 | Group lock |
| masterLock | input | 1 | Master lock |
| ignoreMaster | input | 1 | Make the group ignore the master lock |
| pwmOut | output | 1 | Backlight pulse output |
| activeDuty | output | 16 | Readback of the applied duty word |
| updatePending | output | 1 | Staged value waiting for transfer |

## Verification
Two functions can fall in the same cycle: a staging write and a period-start transfer of a value that was staged earlier. The bench stages one value under the group lock. It then releases the lock and writes a second value in the same cycle, with output disabled so that this edge is a start. The bench expects the first value on the readback with pending still high, and the second value one edge later. A second case writes a new duty in the middle of a running period, and the bench checks that the readback changes exactly at the next boundary and that the following period's high time uses the new value.

// File: rtl/backlight_pwm_pkg.sv
`timescale 1ns/1ps
package backlight_pwm_pkg;

  // Strobes from the control unit to the datapath, valid for one cycle.
  typedef struct packed {
    logic tick;         // clock-enable for the counter
    logic run;          // output enabled
    logic stageWr;      // capture dutyIn into the staging register
    logic transfer;     // move the staged word into the active register
    logic periodStart;  // a new period begins at this edge
  } pwmStrobes_t;

endpackage

// File: rtl/backlight_pwm_ctrl.sv
`timescale 1ns/1ps
module backlight_pwm_ctrl
  import backlight_pwm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clkEn,
  input  logic        pwmEn,
  input  logic        dutyWr,
  input  logic        grpLock,
  input  logic        masterLock,
  input  logic        ignoreMaster,
  input  logic        cntAtZero,
  output pwmStrobes_t strb,
  output logic        updatePending
);

  logic stagedValid;
  logic lockEff;
  logic boundary;
  logic doTransfer;

  // The master lock applies only when the group does not override it.
  assign lockEff    = grpLock | (masterLock & ~ignoreMaster);
  assign boundary   = clkEn & cntAtZero;
  assign doTransfer = boundary & stagedValid & ~lockEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedValid <= 1'b0;
    end else if (dutyWr) begin
      stagedValid <= 1'b1;      // a fresh write always leaves a value waiting
    end else if (doTransfer) begin
      stagedValid <= 1'b0;
    end
  end

  always_comb begin
    strb             = '0;
    strb.tick        = clkEn;
    strb.run         = pwmEn;
    strb.stageWr     = dutyWr;
    strb.transfer    = doTransfer;
    strb.periodStart = boundary & pwmEn;
  end

  assign updatePending = stagedValid & ~lockEff;

  // R8: a pending value that meets a start with no new write is consumed.
  p_pending_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (updatePending && clkEn && cntAtZero && !dutyWr) |=> !stagedValid);

  // R9: a write always leaves a staged value behind, even on a transfer edge.
  p_write_stays_staged_r9: assert property (@(posedge clk) disable iff (!rstN)
    dutyWr |=> stagedValid);

endmodule

// File: rtl/backlight_pwm_dp.sv
`timescale 1ns/1ps
module backlight_pwm_dp
  import backlight_pwm_pkg::*;
#(
  parameter int DUTY_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  pwmStrobes_t                 strb,
  input  logic [$clog2(DUTY_W)-1:0]   bitCnt,
  input  logic [DUTY_W-1:0]           periodIn,
  input  logic                        fracEn,
  input  logic [DUTY_W-1:0]           dutyIn,
  output logic                        cntAtZero,
  output logic [DUTY_W-1:0]           activeDuty,
  output logic                        pwmOut
);

  localparam int BC_W = $clog2(DUTY_W);
  localparam int EB_W = BC_W + 1;

  logic [DUTY_W-1:0] stagedQ, activeQ, cntQ, accQ;
  logic [DUTY_W:0]   lenQ;
  logic              pwmQ;

  logic [EB_W-1:0]   effBits, shAmt;
  logic [DUTY_W-1:0] periodMask, periodMasked, periodEff, lastCnt;
  logic [DUTY_W-1:0] dutyNow, intPart, fracAligned;
  logic [DUTY_W:0]   accSum, lenNew, lenNow;
  logic              carryUse;

  // Effective width: a zero field selects the full duty width.
  assign effBits = (bitCnt == '0) ? EB_W'(DUTY_W) : {1'b0, bitCnt};
  assign shAmt   = EB_W'(DUTY_W) - effBits;

  always_comb begin
    for (int i = 0; i < DUTY_W; i++) begin
      periodMask[i] = (i < int'(effBits));
    end
  end

  assign periodMasked = periodIn & periodMask;
  assign periodEff    = (periodMasked == '0) ? '1 : periodMasked;
  assign lastCnt      = periodEff - 1'b1;
  assign cntAtZero    = (cntQ == '0);

  // The period that begins with a transfer already uses the new word.
  assign dutyNow     = strb.transfer ? stagedQ : activeQ;
  assign intPart     = dutyNow >> shAmt;
  assign fracAligned = dutyNow << effBits;
  assign accSum      = {1'b0, accQ} + {1'b0, fracAligned};
  assign carryUse    = fracEn & accSum[DUTY_W];
  assign lenNew      = {1'b0, intPart} + {{DUTY_W{1'b0}}, carryUse};
  assign lenNow      = strb.periodStart ? lenNew : lenQ;

  // Staging and active duty registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedQ <= '0;
      activeQ <= '0;
    end else begin
      if (strb.transfer) activeQ <= stagedQ;
      if (strb.stageWr)  stagedQ <= dutyIn;
    end
  end

  // Counter, length latch, fraction accumulator and output register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      lenQ <= '0;
      accQ <= '0;
      pwmQ <= 1'b0;
    end else if (!strb.run) begin
      cntQ <= '0;
      accQ <= '0;
      pwmQ <= 1'b0;
    end else if (strb.tick) begin
      cntQ <= (cntQ >= lastCnt) ? '0 : cntQ + 1'b1;
      pwmQ <= ({1'b0, cntQ} < lenNow);
      if (strb.periodStart) begin
        lenQ <= lenNew;
        if (fracEn) accQ <= accSum[DUTY_W-1:0];
      end
    end
  end

  assign activeDuty = activeQ;
  assign pwmOut     = pwmQ;

  // R6: the active word only moves on a clock-enabled edge at the period start.
  p_start_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.tick && cntAtZero) |=> $stable(activeQ));

  // R3: the accumulator is untouched outside period starts.
  p_acc_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.periodStart) |=> $stable(accQ));

endmodule

// File: rtl/backlight_pwm.sv
`timescale 1ns/1ps
module backlight_pwm
  import backlight_pwm_pkg::*;
#(
  parameter int DUTY_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clkEn,
  input  logic                       pwmEn,
  input  logic [$clog2(DUTY_W)-1:0]  bitCnt,
  input  logic [DUTY_W-1:0]          periodIn,
  input  logic                       fracEn,
  input  logic [DUTY_W-1:0]          dutyIn,
  input  logic                       dutyWr,
  input  logic                       grpLock,
  input  logic                       masterLock,
  input  logic                       ignoreMaster,
  output logic                       pwmOut,
  output logic [DUTY_W-1:0]          activeDuty,
  output logic                       updatePending
);

  pwmStrobes_t strb;
  logic        cntAtZero;

  backlight_pwm_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .clkEn        (clkEn),
    .pwmEn        (pwmEn),
    .dutyWr       (dutyWr),
    .grpLock      (grpLock),
    .masterLock   (masterLock),
    .ignoreMaster (ignoreMaster),
    .cntAtZero    (cntAtZero),
    .strb         (strb),
    .updatePending(updatePending)
  );

  backlight_pwm_dp #(.DUTY_W(DUTY_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .bitCnt     (bitCnt),
    .periodIn   (periodIn),
    .fracEn     (fracEn),
    .dutyIn     (dutyIn),
    .cntAtZero  (cntAtZero),
    .activeDuty (activeDuty),
    .pwmOut     (pwmOut)
  );

  // R5: disabled output is low on the next edge.
  p_off_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    !pwmEn |=> !pwmOut);

  // R7: under an effective lock the readback does not move.
  p_locked_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (grpLock || (masterLock && !ignoreMaster)) |=> $stable(activeDuty));

  // R10: without a tick the running output and the readback hold.
  p_tick_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && pwmEn) |=> ($stable(pwmOut) && $stable(activeDuty)));

endmodule

// File: tb/test_backlight_pwm.sv
`timescale 1ns/1ps
module test_backlight_pwm;

  logic        clk = 1'b0;
  logic        rstN;
  logic        clkEn, pwmEn, fracEn, dutyWr, grpLock, masterLock, ignoreMaster;
  logic [3:0]  bitCnt;
  logic [15:0] periodIn, dutyIn;
  logic        pwmOut;
  logic [15:0] activeDuty;
  logic        updatePending;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // Scoreboard state
  int    expQ[$];
  bit    monOn = 0;
  int    monP = 1;
  string monTag = "";

  always #2 clk = ~clk;   // 250 MHz

  backlight_pwm i_backlight_pwm (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .pwmEn(pwmEn), .bitCnt(bitCnt),
    .periodIn(periodIn), .fracEn(fracEn), .dutyIn(dutyIn), .dutyWr(dutyWr),
    .grpLock(grpLock), .masterLock(masterLock), .ignoreMaster(ignoreMaster),
    .pwmOut(pwmOut), .activeDuty(activeDuty), .updatePending(updatePending)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int effBitsOf(input int bc);
    return (bc == 0) ? 16 : bc;
  endfunction

  function automatic int periodOf(input int bc, input int per);
    int m;
    m = per & ((1 << effBitsOf(bc)) - 1);
    return (m == 0) ? 65535 : m;
  endfunction

  // Monitor: counts high samples per period and compares with the queue.
  initial begin
    int n = 0;
    int hi = 0;
    forever begin
      @(negedge clk);
      if (monOn) begin
        hi += int'(pwmOut);
        n++;
        if (n == monP) begin
          int e;
          if (expQ.size() > 0) begin
            e = expQ.pop_front();
            check(hi == e, monTag, hi, e);
          end
          n = 0;
          hi = 0;
        end
      end else begin
        n = 0;
        hi = 0;
      end
    end
  end

  task automatic writeDuty(input int d);
    @(negedge clk); #1;
    dutyIn = 16'(d);
    dutyWr = 1'b1;
    @(negedge clk); #1;
    dutyWr = 1'b0;
  endtask

  // Driver: stages the duty while disabled, pushes expected high counts,
  // then runs the output for nPer periods.
  task automatic runPhase(input int bc, input int per, input int duty,
                          input bit fr, input int nPer, input string tag);
    int beff, p, acc, intp, fa, s, len;
    bitCnt   = 4'(bc);
    periodIn = 16'(per);
    fracEn   = fr;
    writeDuty(duty);
    @(negedge clk);
    beff = effBitsOf(bc);
    p    = periodOf(bc, per);
    acc  = 0;
    for (int k = 0; k < nPer; k++) begin
      intp = (duty & 'hFFFF) >> (16 - beff);
      len  = intp;
      if (fr) begin
        fa  = (duty << beff) & 'hFFFF;
        s   = acc + fa;
        acc = s & 'hFFFF;
        len = intp + (s >> 16);
      end
      expQ.push_back((len > p) ? p : len);
    end
    monP   = p;
    monTag = tag;
    @(negedge clk); #1;
    pwmEn = 1'b1;
    monOn = 1'b1;
    while (expQ.size() > 0) @(negedge clk);
    #1;
    pwmEn = 1'b0;
    monOn = 1'b0;
    @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int hiCnt;
    rstN = 1'b0; clkEn = 1'b1; pwmEn = 1'b0; fracEn = 1'b0; dutyWr = 1'b0;
    grpLock = 1'b0; masterLock = 1'b0; ignoreMaster = 1'b0;
    bitCnt = 4'd4; periodIn = 16'd10; dutyIn = 16'h0;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R5 / R8 reset state
    check(pwmOut == 1'b0, "R5 reset output", int'(pwmOut), 0);
    check(activeDuty == 16'h0, "R5 reset active duty", int'(activeDuty), 0);
    check(updatePending == 1'b0, "R8 reset pending", int'(updatePending), 0);

    // R2: integer only, low bits ignored
    runPhase(4, 10, 'h5FFF, 1'b0, 3, "R2 integer high time");
    runPhase(4, 10, 'h5000, 1'b0, 2, "R2 integer high time clean");
    // R3: fractional averaging
    runPhase(4, 10, 'h5800, 1'b1, 4, "R3 half fraction");
    runPhase(4, 10, 'h3400, 1'b1, 8, "R3 quarter fraction");
    // R1: bit-count 0 and period masking
    runPhase(0, 'h20, 7, 1'b0, 2, "R1 bit-count zero means 16");
    runPhase(4, 'hF3, 'h2000, 1'b0, 3, "R1 period masked");
    // R4: clipping at both ends
    runPhase(4, 5, 'hF000, 1'b0, 2, "R4 duty above period");
    runPhase(4, 5, 'h0000, 1'b0, 2, "R4 zero duty");
    // R1: masked zero period stretches to 65535 counts
    runPhase(0, 0, 100, 1'b0, 1, "R1 zero period");

    // R5: disabled output stays low with nonzero duty
    writeDuty('h9000);
    repeat (3) @(negedge clk);
    check(pwmOut == 1'b0, "R5 disabled output low", int'(pwmOut), 0);
    check(activeDuty == 16'h9000, "R6 disabled transfer", int'(activeDuty), 'h9000);

    // R7: group lock blocks transfer
    @(negedge clk); #1 grpLock = 1'b1;
    writeDuty('h1234);
    repeat (3) @(negedge clk);
    check(activeDuty == 16'h9000, "R7 group lock holds", int'(activeDuty), 'h9000);
    check(updatePending == 1'b0, "R8 pending low while locked", int'(updatePending), 0);
    // R7: master lock alone blocks as well
    #1 grpLock = 1'b0; masterLock = 1'b1;
    repeat (3) @(negedge clk);
    check(activeDuty == 16'h9000, "R7 master lock holds", int'(activeDuty), 'h9000);
    // R7/R8: override bit releases it
    #1 ignoreMaster = 1'b1;
    #1;
    check(updatePending == 1'b1, "R8 pending after release", int'(updatePending), 1);
    @(negedge clk);
    check(activeDuty == 16'h1234, "R7 override applies", int'(activeDuty), 'h1234);
    check(updatePending == 1'b0, "R8 pending cleared", int'(updatePending), 0);
    #1 masterLock = 1'b0; ignoreMaster = 1'b0;

    // R9: write lands on the transfer edge
    @(negedge clk); #1 grpLock = 1'b1;
    writeDuty('hAAAA);
    repeat (2) @(negedge clk);
    #1 grpLock = 1'b0; dutyWr = 1'b1; dutyIn = 16'h5555;
    @(negedge clk);
    check(activeDuty == 16'hAAAA, "R9 older value applied", int'(activeDuty), 'hAAAA);
    check(updatePending == 1'b1, "R9 newer value pending", int'(updatePending), 1);
    #1 dutyWr = 1'b0;
    @(negedge clk);
    check(activeDuty == 16'h5555, "R9 newer value next", int'(activeDuty), 'h5555);
    check(updatePending == 1'b0, "R9 pending cleared", int'(updatePending), 0);

    // R10: no tick, no transfer
    #1 clkEn = 1'b0;
    writeDuty('h7777);
    repeat (3) @(negedge clk);
    check(activeDuty == 16'h5555, "R10 held without tick", int'(activeDuty), 'h5555);
    check(updatePending == 1'b1, "R10 still pending", int'(updatePending), 1);
    #1 clkEn = 1'b1;
    @(negedge clk);
    check(activeDuty == 16'h7777, "R10 transfer on tick", int'(activeDuty), 'h7777);

    // R10/R11: freeze while running, P=10, high time 5
    bitCnt = 4'd4; periodIn = 16'd10; fracEn = 1'b0;
    writeDuty('h5000);
    @(negedge clk); #1 pwmEn = 1'b1;
    repeat (2) @(negedge clk);      // counts 0 and 1 shown
    check(pwmOut == 1'b1, "R11 first counts high", int'(pwmOut), 1);
    #1 clkEn = 1'b0;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      check(pwmOut == 1'b1, "R10 output frozen", int'(pwmOut), 1);
    end
    #1 clkEn = 1'b1;
    repeat (3) @(negedge clk);      // counts 2..4
    check(pwmOut == 1'b1, "R10 count 4 high", int'(pwmOut), 1);
    @(negedge clk);                 // count 5
    check(pwmOut == 1'b0, "R10 counter did not advance", int'(pwmOut), 0);
    #1 pwmEn = 1'b0;
    repeat (2) @(negedge clk);

    // R6: write mid-period, applied at next boundary
    @(negedge clk); #1 pwmEn = 1'b1;
    hiCnt = 0;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      if (j >= 10) hiCnt += int'(pwmOut);
      if (j == 9) begin
        check(activeDuty == 16'h5000, "R6 no mid-period change", int'(activeDuty), 'h5000);
        check(updatePending == 1'b1, "R6 pending mid-period", int'(updatePending), 1);
      end
      if (j == 10) begin
        check(activeDuty == 16'h2000, "R6 applied at boundary", int'(activeDuty), 'h2000);
      end
      if (j == 2) begin #1 dutyIn = 16'h2000; dutyWr = 1'b1; end
      if (j == 3) begin #1 dutyWr = 1'b0; end
    end
    check(hiCnt == 2, "R6 new period high time", hiCnt, 2);
    #1 pwmEn = 1'b0;
    @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule